// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit up-counter advances once per pulse of a slow tick-enable input (nominally 256 per second). A timeout of N seconds therefore corresponds to a compare value of N times 256. When the counter steps onto the programmed compare value, the block raises a level interrupt. If the reset path is armed, it also issues a fixed-length reset-request pulse to the system reset controller.

Every write to a control register is protected. It takes effect only when the two key words have just been written to their two key registers, in the correct order. Software keeps the system alive by sending a protected write that zeroes the counter. A sticky reset-cause bit records that the watchdog caused the last restart. Only the power-on reset clears that bit, so software can read it after the restart.

The register interface is a single-cycle write strobe with address and data, and a combinational read port. The block sits behind an address decoder and drives its reset request into the chip's reset logic.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, the outputs and registers hold these values: control 0, compare 0xFF00, counter 0, status 0, `irq` low and `rst_req` low.
- R2: A write of 0xBABA to the first key register (0xB0), followed by a write of 0xEB10 to the second key register (0xB4), opens the lock. A write to a protected register while the lock is closed has no effect.
- R3: An open lock admits exactly one protected write. The lock closes on any of these: a wrong key value, the keys written in the wrong order, or any other write placed between the two keys. A repeated first key simply restarts the sequence.
- R4: The registers are mapped as follows: control 0xB8, compare 0xBC, status 0xC0, interrupt-clear 0xC4, counter-clear 0xC8 and counter value 0xCC. The counter value register is read-only. Status bit 0 is the reset cause and bit 1 is the pending interrupt. Keys and unused addresses read as 0.
- R5: When control bit 0 is set, the counter rises by one on each clock where `tick_en` is high. When control bit 0 is clear, the counter holds its value.
- R6: A compare value above 0xFF00 is stored as 0xFF00.
- R7: A tick that brings the counter equal to the compare value sets `irq` at that same clock edge. `irq` stays high until a protected write with bit 0 set reaches interrupt-clear.
- R8: The same event with control bit 1 also set drives `rst_req` high for exactly RST_PULSE cycles (default 4). With control set to 0x1, no reset request is made.
- R9: A protected write with bit 0 set to counter-clear zeroes the counter. This wins over a tick in the same cycle.
- R10: The reset cause sets together with the reset request and survives `sys_rst_n`, which clears all other state. A protected write of 0 to status clears it, and so does `por_n`.
- R11: With a compare value of 1, the reset path armed and the counter just cleared, a single tick raises `rst_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, spares the reset cause |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Counter advance enable (256 Hz pulse) |
| irq | output | 1 | Compare-match interrupt level |
| rst_req | output | 1 | Reset request pulse |

## Verification
A write or a tick presented before a clock edge shows up in the read port, `irq` and `rst_req` right after that edge. No result needs more than one edge. The bench drives inputs on the falling edge and samples at the next falling edge, so each expected value is checked exactly one edge after its cause. The reset pulse is measured by counting falling-edge samples from the first one after the hitting tick until the pulse ends. The random phase mixes ticks, pings and interrupt clears. After every step it compares the counter and the interrupt against a model in the bench that keeps its own count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_KEY1  = 8'hB0;
  localparam logic [AW-1:0] A_KEY2  = 8'hB4;
  localparam logic [AW-1:0] A_CTRL  = 8'hB8;
  localparam logic [AW-1:0] A_MATCH = 8'hBC;
  localparam logic [AW-1:0] A_STAT  = 8'hC0;
  localparam logic [AW-1:0] A_ICLR  = 8'hC4;
  localparam logic [AW-1:0] A_CCLR  = 8'hC8;
  localparam logic [AW-1:0] A_CVAL  = 8'hCC;

  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lock_e;

  // Addresses whose writes need the unlock sequence.
  function automatic logic is_prot(input logic [AW-1:0] a);
    return (a == A_CTRL) || (a == A_MATCH) || (a == A_STAT) ||
           (a == A_ICLR) || (a == A_CCLR);
  endfunction

  // Saturate a requested compare value at the largest usable timeout.
  function automatic logic [15:0] clamp_match(input logic [15:0] v,
                                              input logic [15:0] lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int          DW    = 16,
  parameter logic [DW-1:0] KEY_A = 16'hBABA,
  parameter logic [DW-1:0] KEY_B = 16'hEB10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          grant
);
  lock_e st;

  assign grant = we && (st == LK_OPEN) && is_prot(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE;
    end else if (we) begin
      if (addr == A_KEY1 && wdata == KEY_A)
        st <= LK_HALF;
      else if (addr == A_KEY2 && wdata == KEY_B && st == LK_HALF)
        st <= LK_OPEN;
      else
        st <= LK_IDLE;
    end
  end

  AST_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (st != LK_OPEN)); // R3
  AST_OPEN_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_OPEN && $past(st) != LK_OPEN) |-> $past(st) == LK_HALF); // R2
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] match,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] nxt;

  assign nxt = cnt + 1'b1;
  assign hit = run && tick && !clr && (nxt == match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run && tick) cnt <= nxt;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt)); // R5
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(LEN);

  logic [PW-1:0] left;

  assign pulse = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (fire && !pulse) left <= LEN_V;
    else if (pulse)         left <= left - 1'b1;
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pulse) |=> pulse); // R8
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int            DW        = 16,
  parameter logic [DW-1:0] KEY_A     = 16'hBABA,
  parameter logic [DW-1:0] KEY_B     = 16'hEB10,
  parameter logic [DW-1:0] MATCH_MAX = 16'hFF00,
  parameter int            RST_PULSE = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic [7:0]    bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_en,
  output logic          irq,
  output logic          rst_req
);
  logic          rst_n;
  logic          grant;
  logic          wr_ctrl, wr_match, wr_stat, wr_iclr, wr_cclr;
  logic [1:0]    en_q;
  logic [DW-1:0] match_q;
  logic [DW-1:0] cnt;
  logic          hit;
  logic          fire;
  logic          irq_q;
  logic          cause_q;

  assign rst_n = por_n & sys_rst_n;

  wdog_unlock #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .grant(grant)
  );

  assign wr_ctrl  = grant && bus_addr == A_CTRL;
  assign wr_match = grant && bus_addr == A_MATCH;
  assign wr_stat  = grant && bus_addr == A_STAT;
  assign wr_iclr  = grant && bus_addr == A_ICLR && bus_wdata[0];
  assign wr_cclr  = grant && bus_addr == A_CCLR && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      match_q <= MATCH_MAX;
    end else begin
      if (wr_ctrl)  en_q    <= bus_wdata[1:0];
      if (wr_match) match_q <= clamp_match(bus_wdata, MATCH_MAX);
    end
  end

  wdog_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en_q[0]), .tick(tick_en),
    .clr(wr_cclr), .match(match_q), .cnt(cnt), .hit(hit)
  );

  assign fire = hit && en_q[1];

  wdog_pulse #(.LEN(RST_PULSE)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (hit)     irq_q <= 1'b1;
    else if (wr_iclr) irq_q <= 1'b0;
  end

  // Reset cause lives in the power-on domain only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        cause_q <= 1'b0;
    else if (fire)                     cause_q <= 1'b1;
    else if (wr_stat && !bus_wdata[0]) cause_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1:0] = en_q;
      A_MATCH: bus_rdata      = match_q;
      A_STAT:  bus_rdata[1:0] = {irq_q, cause_q};
      A_CVAL:  bus_rdata      = cnt;
      default: bus_rdata      = '0;
    endcase
  end

  AST_MATCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    match_q <= MATCH_MAX); // R6
  AST_MATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_match |=> $stable(match_q)); // R2
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_iclr) |=> irq_q); // R7
  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(en_q[1])); // R8
  AST_CAUSE_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> cause_q); // R10
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq;
  logic        rst_req;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  wdog_top #(.RST_PULSE(PULSE)) i_wdog_top (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq), .rst_req(rst_req)
  );

  function automatic logic [15:0] ref_clamp(input logic [15:0] v);
    return (v >= 16'hFF00) ? 16'hFF00 : v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pwr(input logic [7:0] a, input logic [15:0] d);
    wr(8'hB0, 16'hBABA);
    wr(8'hB4, 16'hEB10);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (!rst_req) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    int exp_cnt;
    logic exp_irq;
    logic [15:0] m;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'hB8, v); chk("R1 ctrl", v, 16'h0);
    rd(8'hBC, v); chk("R1 match", v, 16'hFF00);
    rd(8'hCC, v); chk("R1 count", v, 16'h0);
    rd(8'hC0, v); chk("R1 status", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rst_req", {15'b0, rst_req}, 16'h0);

    // R2 unlock needed
    wr(8'hBC, 16'h0010);
    rd(8'hBC, v); chk("R2 locked write ignored", v, 16'hFF00);
    pwr(8'hBC, 16'h0010);
    rd(8'hBC, v); chk("R2 unlocked write", v, 16'h0010);

    // R3 single use and cancellation
    pwr(8'hBC, 16'h0020); wr(8'hBC, 16'h0030);
    rd(8'hBC, v); chk("R3 single use", v, 16'h0020);
    wr(8'hB0, 16'hBABB); wr(8'hB4, 16'hEB10); wr(8'hBC, 16'h0050);
    rd(8'hBC, v); chk("R3 wrong key", v, 16'h0020);
    wr(8'hB4, 16'hEB10); wr(8'hB0, 16'hBABA); wr(8'hBC, 16'h0050);
    rd(8'hBC, v); chk("R3 wrong order", v, 16'h0020);
    wr(8'hB0, 16'hBABA); wr(8'hCC, 16'h0000); wr(8'hB4, 16'hEB10); wr(8'hBC, 16'h0050);
    rd(8'hBC, v); chk("R3 intervening write", v, 16'h0020);
    wr(8'hB0, 16'hBABA); pwr(8'hBC, 16'h0040);
    rd(8'hBC, v); chk("R3 repeated first key", v, 16'h0040);

    // R6 clamp
    pwr(8'hBC, 16'hFFFF); rd(8'hBC, v); chk("R6 clamp ffff", v, 16'hFF00);
    pwr(8'hBC, 16'hFF01); rd(8'hBC, v); chk("R6 clamp ff01", v, 16'hFF00);
    pwr(8'hBC, 16'hFF00); rd(8'hBC, v); chk("R6 edge ff00", v, 16'hFF00);

    // R5 counting and holding
    pwr(8'hBC, 16'h0010); pwr(8'hB8, 16'h0001); pwr(8'hC8, 16'h0001);
    ticks(5); rd(8'hCC, v); chk("R5 count up", v, 16'd5);
    pwr(8'hB8, 16'h0000); ticks(3); rd(8'hCC, v); chk("R5 hold stopped", v, 16'd5);

    // R4 read-only counter, map
    pwr(8'hCC, 16'h1234); rd(8'hCC, v); chk("R4 count read-only", v, 16'd5);
    rd(8'hB8, v); chk("R4 ctrl readback", v, 16'h0);
    rd(8'hB0, v); chk("R4 key reads zero", v, 16'h0);

    // R7 interrupt level, R8 no reset in irq-only mode
    pwr(8'hBC, 16'h0008); pwr(8'hB8, 16'h0001); pwr(8'hC8, 16'h0001);
    ticks(7); chk("R7 irq before match", {15'b0, irq}, 16'h0);
    ticks(1); chk("R7 irq at match", {15'b0, irq}, 16'h1);
    chk("R8 no reset when unarmed", {15'b0, rst_req}, 16'h0);
    rd(8'hC0, v); chk("R4 status irq bit", v, 16'h0002);
    ticks(3); chk("R7 irq holds", {15'b0, irq}, 16'h1);
    pwr(8'hC4, 16'h0001); chk("R7 irq cleared", {15'b0, irq}, 16'h0);

    // R8 reset pulse length, R10 cause
    pwr(8'hBC, 16'h0004); pwr(8'hB8, 16'h0003); pwr(8'hC8, 16'h0001);
    ticks(3); chk("R8 no early reset", {15'b0, rst_req}, 16'h0);
    ticks(1); pulse_len(n); chk("R8 pulse length", 16'(n), 16'(PULSE));
    rd(8'hC0, v); chk("R10 cause set", {15'b0, v[0]}, 16'h1);
    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1; @(negedge clk);
    rd(8'hC0, v); chk("R10 cause survives sys reset", v, 16'h0001);
    rd(8'hB8, v); chk("R10 sys reset clears ctrl", v, 16'h0);
    pwr(8'hC0, 16'h0000); rd(8'hC0, v); chk("R10 cause cleared", v, 16'h0);

    // R11 near-immediate reset
    pwr(8'hBC, 16'h0001); pwr(8'hB8, 16'h0003); pwr(8'hC8, 16'h0001);
    ticks(1); chk("R11 immediate reset", {15'b0, rst_req}, 16'h1);
    pulse_len(n);
    por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    rd(8'hC0, v); chk("R10 por clears cause", v, 16'h0);

    // R9 clear beats tick
    pwr(8'hB8, 16'h0001); ticks(6);
    wr(8'hB0, 16'hBABA); wr(8'hB4, 16'hEB10);
    tick_en = 1'b1; wr(8'hC8, 16'h0001); tick_en = 1'b0;
    rd(8'hCC, v); chk("R9 clear beats tick", v, 16'h0);

    // Random phase: R5 R7 R9 against bench model
    m = 16'(8 + ($urandom % 32));
    pwr(8'hBC, m); pwr(8'hC8, 16'h0001); pwr(8'hC4, 16'h0001);
    exp_cnt = 0; exp_irq = 1'b0;
    for (int it = 0; it < 300; it++) begin
      int r;
      r = $urandom % 100;
      if (r < 70) begin
        ticks(1);
        exp_cnt = (exp_cnt + 1) & 16'hFFFF;
        if (16'(exp_cnt) == m) exp_irq = 1'b1;
      end else if (r < 82) begin
        pwr(8'hC8, 16'h0001); exp_cnt = 0;
      end else if (r < 92) begin
        pwr(8'hC4, 16'h0001); exp_irq = 1'b0;
      end else begin
        @(negedge clk);
      end
      rd(8'hCC, v); chk("R5 random count", v, 16'(exp_cnt));
      chk("R7 random irq", {15'b0, irq}, {15'b0, exp_irq});
    end
    chk("R6 model clamp", ref_clamp(m), m);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule